// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller for one processor's private cache on a shared, single-transfer bus. It keeps a small direct-mapped array of one-word lines, and each resident line is held in one of three states: clean-exclusive, shared or modified. When the processor writes a word that other caches may also hold, the controller sends the new word out on the bus. Memory and every other holder then update their copies in place, so no copy is invalidated.

Sharing is tracked with a wired-OR shared line. Every cache that holds the address on the bus drives its `shared_out` high. The system ORs these outputs from all other caches and returns the result as `shared_in`. The controller samples `shared_in` on the cycle its own fill or update is granted, and uses it to choose the state the line takes next. While the controller is idle on the bus, it snoops the transfers of other caches. On a snooped read of a line it holds modified, it supplies the word. On a snooped update of a line it holds, it overwrites its own copy.

Processor requests use a valid/ready handshake. The controller takes one request at a time: `cpu_req_ready` is high only when it is idle. A response stays valid and unchanged until `cpu_rsp_ready` is seen. A bus transfer completes in the single cycle in which `mst_valid` and `bus_gnt` are both high. Until that cycle the controller holds its request steady.

Top module: `fw_update_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and `mst_valid`, `cpu_rsp_valid` and `shared_out` are 0. No snooped address is reported as held.
- R2: A read that hits returns the stored word and causes no bus transfer.
- R3: A write that hits a modified line updates the word locally with no bus transfer, and the line stays modified.
- R4: A write that hits a clean-exclusive line updates the word locally with no bus transfer, and the line becomes modified.
- R5: A write that hits a shared line issues one update transfer (`mst_op` = 2'b01) carrying the address and the new word. If `shared_in` is 1 at the grant, the line stays shared. If it is 0, the line becomes clean-exclusive, and the next write completes locally.
- R6: A miss issues a fill transfer (`mst_op` = 2'b00) and loads `bus_rdata`. A read miss ends shared if `shared_in` was 1 at the grant, otherwise clean-exclusive. A write miss with `shared_in` 0 ends modified, with no further transfer. A write miss with `shared_in` 1 follows the fill with one update transfer.
- R7: When a snooped fill (`snp_op` = 2'b00) hits a held line, `shared_out` is 1 in that same cycle and the line becomes shared. If the line was modified, `supply_valid` is also 1 and `supply_data` carries the word.
- R8: When a snooped update (`snp_op` = 2'b01) hits a held line, `shared_out` is 1 in that cycle, the stored word is replaced by `snp_data`, and the line is shared.
- R9: A snooped address whose tag does not match, or whose line is invalid, leaves `shared_out` and `supply_valid` at 0 and does not change the stored line.
- R10: A miss whose victim line is modified first issues a writeback (`mst_op` = 2'b10) of the victim's word and address, and then the fill. A clean victim is dropped with no transfer.
- R11: A request is accepted only while `cpu_req_ready` is 1. A response stays valid with unchanged data until it is accepted, and no new request is taken while the response is pending.
- R12: While `mst_valid` is 1 and `bus_gnt` is 0, `mst_op`, `mst_addr` and `mst_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address; the low bits select the line |
| cpu_req_wdata | input | DW | Write word |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor accepts the response |
| cpu_rsp_rdata | output | DW | Word read, or word written |
| mst_valid | output | 1 | Controller requests a bus transfer |
| mst_op | output | 2 | 00 fill, 01 update, 10 writeback |
| mst_addr | output | AW | Transfer address |
| mst_wdata | output | DW | Word for an update or writeback |
| bus_gnt | input | 1 | Transfer completes in this cycle |
| bus_rdata | input | DW | Fill data, valid with the grant |
| shared_in | input | 1 | OR of the other caches' shared outputs |
| snp_valid | input | 1 | Another cache's transfer is on the bus |
| snp_op | input | 2 | Snooped operation, encoded as `mst_op` |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped update word |
| shared_out | output | 1 | This cache holds the snooped address |
| supply_valid | output | 1 | This cache supplies modified data |
| supply_data | output | DW | Supplied word |

## Verification
The assertions check the properties that hold on every cycle:
- a pending response is held steady (R11);
- an ungranted bus request is held steady (R12);
- an update transfer is issued only from a shared line (R5);
- a writeback never names the requested address (R10);
- the local write port and the snoop write port never write the same line in the same cycle (R8);
- no bus request is made while idle (R1).

The protocol itself can only be seen across sequences, so the bench's scenarios cover it. These are the state a line takes after sampling `shared_in`, the number and kind of bus transfers each request causes, and the data that comes back after a writeback or after a snooped update. They also include whether a snoop changes how the next local write behaves.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_EXCL  = 2'd1,
    LS_SHRD  = 2'd2,
    LS_DIRTY = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_FILL = 2'd0,
    BOP_UPD  = 2'd1,
    BOP_WB   = 2'd2,
    BOP_NONE = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    C_IDLE, C_LOOK, C_WB, C_FILL, C_BCAST, C_RESP
  } ctrl_e;
endpackage

// File: rtl/fw_line_store.sv
module fw_line_store
  import fw_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TW    = 13,
  parameter int DW    = 32,
  localparam int IW   = $clog2(LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  lk_idx,
  output logic [TW-1:0]  lk_tag,
  output line_st_e       lk_st,
  output logic [DW-1:0]  lk_data,
  input  logic [IW-1:0]  sn_idx,
  output logic [TW-1:0]  sn_tag,
  output line_st_e       sn_st,
  output logic [DW-1:0]  sn_data,
  input  logic           lw_en,
  input  logic [IW-1:0]  lw_idx,
  input  logic [TW-1:0]  lw_tag,
  input  line_st_e       lw_st,
  input  logic [DW-1:0]  lw_data,
  input  logic           sw_en,
  input  logic [IW-1:0]  sw_idx,
  input  line_st_e       sw_st,
  input  logic           sw_data_en,
  input  logic [DW-1:0]  sw_data
);
  logic [TW-1:0] tag_q  [LINES];
  line_st_e      st_q   [LINES];
  logic [DW-1:0] data_q [LINES];

  assign lk_tag  = tag_q[lk_idx];
  assign lk_st   = st_q[lk_idx];
  assign lk_data = data_q[lk_idx];
  assign sn_tag  = tag_q[sn_idx];
  assign sn_st   = st_q[sn_idx];
  assign sn_data = data_q[sn_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (sw_en) st_q[sw_idx] <= sw_st;
      if (lw_en) st_q[lw_idx] <= lw_st;
    end
  end

  always_ff @(posedge clk) begin
    if (sw_en && sw_data_en) data_q[sw_idx] <= sw_data;
    if (lw_en) begin
      data_q[lw_idx] <= lw_data;
      tag_q[lw_idx]  <= lw_tag;
    end
  end

  AST_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(lw_en && sw_en && (lw_idx == sw_idx))); // R8
endmodule

// File: rtl/fw_snoop_unit.sv
module fw_snoop_unit
  import fw_pkg::*;
#(
  parameter int TW = 13,
  parameter int DW = 32
) (
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [TW-1:0] snp_tag,
  input  logic [DW-1:0] snp_data,
  input  logic [TW-1:0] ln_tag,
  input  line_st_e      ln_st,
  input  logic [DW-1:0] ln_data,
  output logic          shared_out,
  output logic          supply_valid,
  output logic [DW-1:0] supply_data,
  output logic          sw_en,
  output line_st_e      sw_st,
  output logic          sw_data_en,
  output logic [DW-1:0] sw_data
);
  logic holds, is_fill, is_upd;

  always_comb begin
    holds        = (ln_st != LS_INV) && (ln_tag == snp_tag);
    is_fill      = (snp_op == BOP_FILL);
    is_upd       = (snp_op == BOP_UPD);
    shared_out   = snp_valid && holds && (is_fill || is_upd);
    supply_valid = shared_out && is_fill && (ln_st == LS_DIRTY);
    supply_data  = ln_data;
    sw_en        = shared_out;
    sw_st        = LS_SHRD;
    sw_data_en   = is_upd;
    sw_data      = snp_data;
  end
endmodule

// File: rtl/fw_update_cache.sv
module fw_update_cache
  import fw_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_we,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  input  logic          cpu_rsp_ready,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          mst_valid,
  output logic [1:0]    mst_op,
  output logic [AW-1:0] mst_addr,
  output logic [DW-1:0] mst_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          shared_out,
  output logic          supply_valid,
  output logic [DW-1:0] supply_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  ctrl_e         st_q, st_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;

  logic [IW-1:0] req_idx;
  logic [TW-1:0] req_tag;
  logic [TW-1:0] lk_tag, sn_tag;
  line_st_e      lk_st, sn_st;
  logic [DW-1:0] lk_data, sn_data;

  logic          lw_en;
  logic [TW-1:0] lw_tag;
  line_st_e      lw_st;
  logic [DW-1:0] lw_data;
  logic          sw_en, sw_data_en;
  line_st_e      sw_st;
  logic [DW-1:0] sw_data;

  logic          hit, look_stall;

  assign req_idx = addr_q[IW-1:0];
  assign req_tag = addr_q[AW-1:IW];

  fw_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
    .sn_idx(snp_addr[IW-1:0]), .sn_tag(sn_tag), .sn_st(sn_st), .sn_data(sn_data),
    .lw_en(lw_en), .lw_idx(req_idx), .lw_tag(lw_tag), .lw_st(lw_st), .lw_data(lw_data),
    .sw_en(sw_en), .sw_idx(snp_addr[IW-1:0]), .sw_st(sw_st),
    .sw_data_en(sw_data_en), .sw_data(sw_data)
  );

  fw_snoop_unit #(.TW(TW), .DW(DW)) u_snoop (
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_addr[AW-1:IW]),
    .snp_data(snp_data),
    .ln_tag(sn_tag), .ln_st(sn_st), .ln_data(sn_data),
    .shared_out(shared_out), .supply_valid(supply_valid), .supply_data(supply_data),
    .sw_en(sw_en), .sw_st(sw_st), .sw_data_en(sw_data_en), .sw_data(sw_data)
  );

  assign hit           = (lk_st != LS_INV) && (lk_tag == req_tag);
  assign look_stall    = snp_valid && (snp_addr[IW-1:0] == req_idx);
  assign cpu_req_ready = (st_q == C_IDLE);
  assign cpu_rsp_valid = (st_q == C_RESP);
  assign cpu_rsp_rdata = rdata_q;

  always_comb begin
    st_d      = st_q;
    rdata_d   = rdata_q;
    lw_en     = 1'b0;
    lw_tag    = req_tag;
    lw_st     = lk_st;
    lw_data   = lk_data;
    mst_valid = 1'b0;
    mst_op    = BOP_FILL;
    mst_addr  = addr_q;
    mst_wdata = wdata_q;
    unique case (st_q)
      C_IDLE: if (cpu_req_valid) st_d = C_LOOK;
      C_LOOK: if (!look_stall) begin
        if (hit && !we_q) begin
          rdata_d = lk_data;
          st_d    = C_RESP;
        end else if (hit && (lk_st == LS_SHRD)) begin
          st_d = C_BCAST;
        end else if (hit) begin
          lw_en   = 1'b1;
          lw_st   = LS_DIRTY;
          lw_data = wdata_q;
          rdata_d = wdata_q;
          st_d    = C_RESP;
        end else begin
          st_d = (lk_st == LS_DIRTY) ? C_WB : C_FILL;
        end
      end
      C_WB: begin
        mst_valid = 1'b1;
        mst_op    = BOP_WB;
        mst_addr  = {lk_tag, req_idx};
        mst_wdata = lk_data;
        if (bus_gnt) begin
          lw_en  = 1'b1;
          lw_tag = lk_tag;
          lw_st  = LS_INV;
          st_d   = C_FILL;
        end
      end
      C_FILL: begin
        mst_valid = 1'b1;
        mst_op    = BOP_FILL;
        if (bus_gnt) begin
          lw_en   = 1'b1;
          lw_data = bus_rdata;
          if (!we_q) begin
            lw_st   = shared_in ? LS_SHRD : LS_EXCL;
            rdata_d = bus_rdata;
            st_d    = C_RESP;
          end else if (shared_in) begin
            lw_st = LS_SHRD;
            st_d  = C_BCAST;
          end else begin
            lw_st   = LS_DIRTY;
            lw_data = wdata_q;
            rdata_d = wdata_q;
            st_d    = C_RESP;
          end
        end
      end
      C_BCAST: begin
        mst_valid = 1'b1;
        mst_op    = BOP_UPD;
        if (bus_gnt) begin
          lw_en   = 1'b1;
          lw_data = wdata_q;
          lw_st   = shared_in ? LS_SHRD : LS_EXCL;
          rdata_d = wdata_q;
          st_d    = C_RESP;
        end
      end
      C_RESP: if (cpu_rsp_ready) st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (cpu_req_valid && cpu_req_ready) begin
        we_q    <= cpu_req_we;
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !mst_valid); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata) && !cpu_req_ready); // R11
  AST_MST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && !bus_gnt |=> mst_valid && $stable(mst_op) && $stable(mst_addr) && $stable(mst_wdata)); // R12
  AST_UPD_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && (mst_op == BOP_UPD) |-> hit && (lk_st == LS_SHRD)); // R5
  AST_WB_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && (mst_op == BOP_WB) |-> (mst_addr != addr_q)); // R10
endmodule

// File: tb/sim_fw_update_cache.sv
module sim_fw_update_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0, cpu_rsp_ready = 1'b1;
  logic [15:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mst_valid, bus_gnt, gnt_en = 1'b1, shared_in = 1'b0;
  logic [1:0]  mst_op;
  logic [15:0] mst_addr;
  logic [31:0] mst_wdata, bus_rdata;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = 2'd0;
  logic [15:0] snp_addr = '0;
  logic [31:0] snp_data = '0;
  logic        shared_out, supply_valid;
  logic [31:0] supply_data;

  int n_chk = 0, n_bad = 0, ops_total = 0;
  logic [1:0]  last_op = 2'd3;
  logic [31:0] mem [256];

  always #5 clk = ~clk;

  fw_update_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mst_valid(mst_valid), .mst_op(mst_op), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .shared_in(shared_in),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .snp_data(snp_data),
    .shared_out(shared_out), .supply_valid(supply_valid), .supply_data(supply_data)
  );

  assign bus_gnt   = mst_valid && gnt_en;
  assign bus_rdata = mem[mst_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h1000_0000 | i;
    end else if (mst_valid && bus_gnt) begin
      ops_total <= ops_total + 1;
      last_op   <= mst_op;
      if (mst_op != 2'd0) mem[mst_addr[7:0]] <= mst_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [15:0] a, input logic [31:0] d,
                        input logic sh, output logic [31:0] rd, output int ops,
                        output logic [1:0] lop);
    int base;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    base = ops_total;
    shared_in = sh; cpu_req_valid = 1'b1; cpu_req_we = we;
    cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata; ops = ops_total - base; lop = last_op;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d,
                       output logic sh, output logic sv, output logic [31:0] sd);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a; snp_data = d;
    #1;
    sh = shared_out; sv = supply_valid; sd = supply_data;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        sh;
    logic [31:0] exp;
    logic [1:0]  ops;
    logic [1:0]  lop;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 16'h0010, 32'h0,         1'b0, 32'h1000_0010, 2'd1, 2'd0, 4'd6},  // R6 read miss, no sharer
    '{1'b1, 16'h0010, 32'hAAAA_0001, 1'b0, 32'hAAAA_0001, 2'd0, 2'd3, 4'd4},  // R4 exclusive write hit
    '{1'b1, 16'h0010, 32'hAAAA_0002, 1'b0, 32'hAAAA_0002, 2'd0, 2'd3, 4'd3},  // R3 modified write hit
    '{1'b0, 16'h0018, 32'h0,         1'b0, 32'h1000_0018, 2'd2, 2'd0, 4'd10}, // R10 modified victim
    '{1'b0, 16'h0010, 32'h0,         1'b1, 32'hAAAA_0002, 2'd1, 2'd0, 4'd10}, // R10 clean victim, data written back
    '{1'b1, 16'h0010, 32'hBBBB_0001, 1'b1, 32'hBBBB_0001, 2'd1, 2'd1, 4'd5},  // R5 shared, sharer present
    '{1'b1, 16'h0010, 32'hBBBB_0002, 1'b0, 32'hBBBB_0002, 2'd1, 2'd1, 4'd5},  // R5 still shared, no sharer now
    '{1'b1, 16'h0010, 32'hBBBB_0003, 1'b0, 32'hBBBB_0003, 2'd0, 2'd3, 4'd5},  // R5 dropped to exclusive
    '{1'b1, 16'h0021, 32'hCCCC_0001, 1'b0, 32'hCCCC_0001, 2'd1, 2'd0, 4'd6},  // R6 write miss, no sharer
    '{1'b1, 16'h0021, 32'hCCCC_0002, 1'b0, 32'hCCCC_0002, 2'd0, 2'd3, 4'd3},  // R3 became modified
    '{1'b1, 16'h0032, 32'hDDDD_0001, 1'b1, 32'hDDDD_0001, 2'd2, 2'd1, 4'd6},  // R6 write miss, sharer
    '{1'b0, 16'h0032, 32'h0,         1'b0, 32'hDDDD_0001, 2'd0, 2'd3, 4'd2}   // R2 read hit
  };

  task automatic run_all();
    logic [31:0] rd, sd, a0;
    logic [1:0]  lop, op0;
    logic        sh, sv;
    int          ops;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", {31'd0, cpu_req_ready}, 32'd1);
    check("R1 mst_valid", {31'd0, mst_valid}, 32'd0);
    check("R1 rsp_valid", {31'd0, cpu_rsp_valid}, 32'd0);
    snoop(2'd0, 16'h0000, 32'h0, sh, sv, sd);
    check("R1 no line held", {30'd0, sh, sv}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      do_req(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].sh, rd, ops, lop);
      check($sformatf("R%0d vector %0d data", VECS[i].req, i), rd, VECS[i].exp);
      check($sformatf("R%0d vector %0d bus ops", VECS[i].req, i), ops, {30'd0, VECS[i].ops});
      if (VECS[i].ops != 2'd0)
        check($sformatf("R%0d vector %0d last op", VECS[i].req, i), {30'd0, lop}, {30'd0, VECS[i].lop});
    end
    check("R5 memory updated by broadcast", mem[8'h10], 32'hBBBB_0002);
    check("R6 memory updated by fill+update", mem[8'h32], 32'hDDDD_0001);

    // R7: snooped fill of modified line supplies data and shares the line
    snoop(2'd0, 16'h0010, 32'h0, sh, sv, sd);
    check("R7 shared_out", {31'd0, sh}, 32'd1);
    check("R7 supply_valid", {31'd0, sv}, 32'd1);
    check("R7 supply_data", sd, 32'hBBBB_0003);
    do_req(1'b1, 16'h0010, 32'hEEEE_0001, 1'b0, rd, ops, lop);
    check("R7 now shared: write broadcasts", ops, 32'd1);
    check("R7 broadcast op", {30'd0, lop}, 32'd1);

    // R8: snooped update overwrites data
    snoop(2'd1, 16'h0032, 32'hFFFF_0001, sh, sv, sd);
    check("R8 shared_out", {31'd0, sh}, 32'd1);
    check("R8 no supply", {31'd0, sv}, 32'd0);
    do_req(1'b0, 16'h0032, 32'h0, 1'b0, rd, ops, lop);
    check("R8 data replaced", rd, 32'hFFFF_0001);
    check("R8 read hit no bus", ops, 32'd0);

    // R9: non-matching snoops
    snoop(2'd0, 16'h003A, 32'h0, sh, sv, sd);
    check("R9 tag mismatch", {30'd0, sh, sv}, 32'd0);
    snoop(2'd0, 16'h0005, 32'h0, sh, sv, sd);
    check("R9 invalid line", {30'd0, sh, sv}, 32'd0);
    snoop(2'd1, 16'h002A, 32'h1234_5678, sh, sv, sd);
    check("R9 mismatched update", {30'd0, sh, sv}, 32'd0);
    do_req(1'b0, 16'h0032, 32'h0, 1'b0, rd, ops, lop);
    check("R9 line unchanged", rd, 32'hFFFF_0001);

    // R11: response back-pressure
    cpu_rsp_ready = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = 16'h0021;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 rsp held", {cpu_rsp_valid, cpu_req_ready, 30'd0}, {1'b1, 1'b0, 30'd0});
      check("R11 rsp data", cpu_rsp_rdata, 32'hCCCC_0002);
    end
    cpu_rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 idle again", {31'd0, cpu_req_ready}, 32'd1);

    // R12: request held while not granted
    gnt_en = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = 16'h0044; shared_in = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!mst_valid) @(negedge clk);
    a0 = {16'd0, mst_addr}; op0 = mst_op;
    check("R12 fill addr", a0, 32'h0000_0044);
    check("R12 fill op", {30'd0, op0}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 held", {mst_valid, 13'd0, mst_op, mst_addr}, {1'b1, 13'd0, op0, a0[15:0]});
    end
    gnt_en = 1'b1;
    while (!cpu_rsp_valid) @(negedge clk);
    check("R12 data after grant", cpu_rsp_rdata, 32'h1000_0044);
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule